// File: doc/BRIEF.md
# MAC Result Saturation Unit

This block turns a 64-bit signed multiply-accumulate result into a 32-bit register value. The result arrives as two 32-bit words. The high word supplies bits 63 to 32. The block clamps the combined value to the signed 48-bit range and returns the 32-bit field that sits at bits 47 down to 16 of the clamped number. It also produces the processor flags for the operation. The V flag is a copy of an externally held, sticky overflow-detect bit. The C flag is always cleared.

A start strobe captures the two accumulator words and the overflow bit. One cycle later the block presents the result together with a single-cycle valid strobe. The flags take two routes. A bypass route gives conditional branch and conditional-load logic the newest flag values from the valid cycle onward. The status-word copy of the flags only picks up the new values at the first instruction-retire pulse that comes after the valid cycle, so it trails by one instruction.

The block only reads the accumulator words and the overflow bit and never writes them. Any second source operand is handled outside the block and has no input here.

Top module: `mac_sat48_unit`

## Requirements
- R1: One cycle after a clock edge that samples `start_i` high, `res_vld_o` is 1 for exactly that one cycle. `res_vld_o` is 0 in every other cycle, including after reset.
- R2: The accumulator value is {`acc_hi_i`,`acc_lo_i`}, read as a signed 64-bit number. If it is greater than or equal to 0x00007FFF_FFFFFFFF, `res_o` is 0x7FFFFFFF in the valid cycle.
- R3: If the accumulator value is less than or equal to 0xFFFF8000_00000000 (signed), `res_o` is 0x80000000 in the valid cycle.
- R4: For any value strictly between the two limits, `res_o` equals bits 47 down to 16 of the accumulator value in the valid cycle.
- R5: In the valid cycle and in every later cycle up to the next valid cycle, `byp_v_o` equals the `ovf_bit_i` value sampled with the start strobe.
- R6: `byp_c_o` and `sw_c_o` are always 0.
- R7: A pending update of the status-word V flag (`sw_v_o`) loads at the first clock edge after the valid cycle that samples `retire_i` high. A retire pulse that is sampled in the valid cycle itself does not load that operation's flag.
- R8: After reset, `sw_v_o` is 0 and `byp_v_o` is 0. `sw_v_o` changes only at an edge where `retire_i` is high and an update is pending.
- R9: While `start_i` is low, changes on `acc_hi_i`, `acc_lo_i` and `ovf_bit_i` have no effect. `res_o` and `byp_v_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; captures the operands |
| acc_hi_i | input | 32 | Accumulator bits 63..32 |
| acc_lo_i | input | 32 | Accumulator bits 31..0 |
| ovf_bit_i | input | 1 | Sticky MAC overflow-detect bit |
| retire_i | input | 1 | Instruction-retire pulse |
| res_o | output | 32 | Bits 47..16 of the clamped value |
| res_vld_o | output | 1 | One-cycle result-valid strobe |
| byp_v_o | output | 1 | V flag on the branch bypass route |
| byp_c_o | output | 1 | C flag on the branch bypass route |
| sw_v_o | output | 1 | V flag in the status word |
| sw_c_o | output | 1 | C flag in the status word |

## Verification
A wrong clamp decision appears on `res_o` in the valid cycle, the cycle right after the start strobe. Values just above 0x00007FFF_FFFFFFFF and just below 0xFFFF8000_00000000 matter most, because there the clamped field and the raw field differ in the top bit. A pending-flag register that is wrong shows up on `sw_v_o` at the following retire pulse, or on `byp_v_o` in the idle cycles after the valid cycle. Operand registers that load while idle show up on `res_o` one cycle after the inputs move.

// File: rtl/mac_sat48_unit.sv
module mac_sat48_unit #(
  parameter int WORD_W  = 32,
  parameter int SAT_W   = 48,
  parameter int OUT_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] acc_hi_i,
  input  logic [WORD_W-1:0] acc_lo_i,
  input  logic              ovf_bit_i,
  input  logic              retire_i,
  output logic [WORD_W-1:0] res_o,
  output logic              res_vld_o,
  output logic              byp_v_o,
  output logic              byp_c_o,
  output logic              sw_v_o,
  output logic              sw_c_o
);

  localparam int ACC_W = 2 * WORD_W;
  localparam logic signed [ACC_W-1:0] SAT_MAX = (ACC_W'(1) <<< (SAT_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] SAT_MIN = -(ACC_W'(1) <<< (SAT_W - 1));
  localparam logic [WORD_W-1:0] FIELD_MAX = SAT_MAX[OUT_LSB +: WORD_W];
  localparam logic [WORD_W-1:0] FIELD_MIN = SAT_MIN[OUT_LSB +: WORD_W];

  logic [WORD_W-1:0] hi_q, lo_q;
  logic              ovf_q, vld_q;
  logic              pend_q, pend_v_q, sw_v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      ovf_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= start_i;
      if (start_i) begin
        hi_q  <= acc_hi_i;
        lo_q  <= acc_lo_i;
        ovf_q <= ovf_bit_i;
      end
    end
  end

  logic signed [ACC_W-1:0] acc_s, sat_s;
  assign acc_s = $signed({hi_q, lo_q});

  always_comb begin
    if (acc_s >= SAT_MAX)      sat_s = SAT_MAX;
    else if (acc_s <= SAT_MIN) sat_s = SAT_MIN;
    else                       sat_s = acc_s;
  end

  assign res_o     = sat_s[OUT_LSB +: WORD_W];
  assign res_vld_o = vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pend_v_q <= 1'b0;
      sw_v_q   <= 1'b0;
    end else begin
      if (retire_i && pend_q) sw_v_q <= pend_v_q;
      if (vld_q) begin
        pend_q   <= 1'b1;
        pend_v_q <= ovf_q;
      end else if (retire_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign byp_v_o = vld_q ? ovf_q : (pend_q ? pend_v_q : sw_v_q);
  assign byp_c_o = 1'b0;
  assign sw_v_o  = sw_v_q;
  assign sw_c_o  = 1'b0;

  logic signed [ACC_W-1:0] in_s;
  assign in_s = $signed({acc_hi_i, acc_lo_i});

  p_vld_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |=> !res_vld_o || $past(start_i));
  p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> res_vld_o);
  p_no_vld_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !res_vld_o);
  p_clamp_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && in_s >= SAT_MAX) |=> res_o == FIELD_MAX);
  p_clamp_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && in_s <= SAT_MIN) |=> res_o == FIELD_MIN);
  p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && in_s > SAT_MIN && in_s < SAT_MAX) |=> res_o == $past(in_s[OUT_LSB +: WORD_W]));
  p_byp_v_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> byp_v_o == $past(ovf_bit_i));
  p_byp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !res_vld_o) |=> $stable(byp_v_o));
  p_sw_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && !pend_q) |=> $stable(sw_v_o));
  p_sw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_i |=> $stable(sw_v_o));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(res_o));

endmodule

// File: tb/mac_sat48_unit_tb_top.sv
module mac_sat48_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] acc_hi_i = '0, acc_lo_i = '0;
  logic        ovf_bit_i = 1'b0;
  logic        retire_i = 1'b0;
  logic [31:0] res_o;
  logic        res_vld_o, byp_v_o, byp_c_o, sw_v_o, sw_c_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit m_pend = 1'b0, m_pend_v = 1'b0, m_sw_v = 1'b0, m_last_v = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_sat48_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .acc_hi_i(acc_hi_i), .acc_lo_i(acc_lo_i),
    .ovf_bit_i(ovf_bit_i), .retire_i(retire_i), .res_o(res_o), .res_vld_o(res_vld_o),
    .byp_v_o(byp_v_o), .byp_c_o(byp_c_o), .sw_v_o(sw_v_o), .sw_c_o(sw_c_o));

  function automatic logic [31:0] exp_res(input logic [63:0] v);
    logic signed [63:0] s;
    s = $signed(v);
    if (s >= 64'sh0000_7FFF_FFFF_FFFF) return 32'h7FFF_FFFF;
    if (s <= $signed(64'hFFFF_8000_0000_0000)) return 32'h8000_0000;
    return v[47:16];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [63:0] v, input bit ovf, input bit ret_in_vld);
    @(negedge clk);
    start_i = 1'b1; acc_hi_i = v[63:32]; acc_lo_i = v[31:0]; ovf_bit_i = ovf;
    @(negedge clk);
    start_i = 1'b0;
    chk("R1 vld", res_vld_o, 1);
    chk("R2/R3/R4 res", res_o, exp_res(v));
    chk("R5 byp_v", byp_v_o, ovf);
    chk("R6 c", {byp_c_o, sw_c_o}, 0);
    if (ret_in_vld) begin
      retire_i = 1'b1;
      if (m_pend) m_sw_v = m_pend_v;
    end
    m_pend = 1'b1; m_pend_v = ovf; m_last_v = ovf;
    acc_hi_i = $urandom; acc_lo_i = $urandom; ovf_bit_i = ~ovf;
    @(negedge clk);
    retire_i = 1'b0;
    chk("R1 strobe low", res_vld_o, 0);
    chk("R9 res hold", res_o, exp_res(v));
    chk("R5 byp hold", byp_v_o, m_last_v);
    chk("R7 sw lag", sw_v_o, m_sw_v);
  endtask

  task automatic retire_pulse();
    @(negedge clk);
    retire_i = 1'b1;
    if (m_pend) begin m_sw_v = m_pend_v; m_pend = 1'b0; end
    @(negedge clk);
    retire_i = 1'b0;
    chk("R7 sw load", sw_v_o, m_sw_v);
    chk("R8 byp after retire", byp_v_o, m_last_v);
  endtask

  function automatic logic [63:0] pick();
    logic [63:0] base;
    logic [63:0] off;
    off = 64'($urandom_range(0, 8)) - 64'd4;
    case ($urandom_range(0, 5))
      0: base = 64'h0000_7FFF_FFFF_FFFF;
      1: base = 64'hFFFF_8000_0000_0000;
      2: base = {$urandom, $urandom};
      3: base = {{16{1'b0}}, 16'($urandom), $urandom};
      4: base = {{16{1'b1}}, 16'($urandom), $urandom};
      default: base = 64'h0;
    endcase
    return base + off;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R8 reset sw_v", sw_v_o, 0);
    chk("R8 reset byp_v", byp_v_o, 0);
    chk("R1 reset vld", res_vld_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_op(64'h0000_7FFF_FFFF_FFFF, 1'b1, 1'b0);
    chk("R8 sw no retire", sw_v_o, 0);
    retire_pulse();
    chk("R7 sw takes 1", sw_v_o, 1);
    do_op(64'h0000_7FFF_FFFF_FFFE, 1'b0, 1'b0);
    do_op(64'h0000_8000_0000_0000, 1'b0, 1'b0);
    do_op(64'hFFFF_8000_0000_0000, 1'b1, 1'b0);
    do_op(64'hFFFF_8000_0000_0001, 1'b0, 1'b0);
    do_op(64'hFFFF_7FFF_FFFF_FFFF, 1'b1, 1'b0);
    do_op(64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    do_op(64'h8000_0000_0000_0000, 1'b1, 1'b0);
    do_op(64'h0000_0000_0000_0000, 1'b0, 1'b0);
    do_op(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    do_op(64'h0000_1234_5678_9ABC, 1'b1, 1'b1);
    chk("R7 retire in vld keeps old", sw_v_o, 0);
    retire_pulse();
    chk("R7 retire after vld", sw_v_o, 1);
    for (int i = 0; i < 300; i++) begin
      do_op(pick(), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 1) == 1) retire_pulse();
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule